// File: doc/BRIEF.md
# Page Write Collector with Timed Commit

This block sits between a two-wire serial slave and a 128-byte storage array. Once the slave has decoded a write command it opens a page with the starting word address. It then passes each received data byte with a strobe. The block collects these bytes in a four-slot page latch. The upper five address bits name the page and stay fixed. The lower two bits step through the slots and wrap, so a fifth byte lands on top of the first.

Nothing reaches the array while bytes are being collected. A stop strobe with at least one byte in the latch starts a self-timed programming window, and `busy` is held high for `WRITE_CYCLES` clocks. During that window the block ignores every request and the read port holds its last value. At the end of the window all received slots are written to the array in a single clock. Slots that were not received keep their old contents. A stop with an empty latch, or an abort from a repeated start, discards the page and leaves `busy` low.

Top module: `pgwr_commit`

## Requirements
- R1: After reset `busy` is 0, `arr_we` is 0, `rd_data` is 0 and every array location reads as 0.
- R2: Opening at address A, sending one byte D and then stop leaves A reading D after `busy` falls, and changes no other location.
- R3: Bytes go to consecutive offsets within the page. The offset is address bits [1:0] and wraps from 3 to 0, while the page (bits [6:2]) stays fixed. A page opened at offset 2 fills offsets 2, 3, 0, 1.
- R4: If more than four bytes arrive before stop, the fifth and later bytes overwrite the slots filled earlier, in wrap order.
- R5: Received bytes are not visible in the array before stop; a read during collection returns the old contents.
- R6: A stop with at least one received byte raises `busy` on the next clock edge. `busy` then stays high for exactly `WRITE_CYCLES` cycles.
- R7: Page locations that received no byte keep their previous contents after the commit.
- R8: A stop with no bytes received, or an abort, does not raise `busy` and writes nothing. A later stop without a new open also writes nothing.
- R9: While `busy` is high, open, byte, stop and abort requests are all ignored. They leave no trace in the array and do not lengthen the window.
- R10: When `busy` is low, `rd_data` shows the array word at `rd_addr` one clock later. While `busy` is high, `rd_data` holds its value.
- R11: The array is written in one clock only, the last cycle of the window. `arr_we` bit b flags offset b, and `arr_wdata[8b+7:8b]` carries its byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_open | input | 1 | Open a page write at `wr_addr` |
| wr_addr | input | 7 | Starting word address |
| wr_byte_vld | input | 1 | Data byte strobe |
| wr_byte | input | 8 | Data byte |
| wr_stop | input | 1 | Stop strobe; starts the commit when bytes are held |
| wr_abort | input | 1 | Discard the page (repeated start) |
| busy | output | 1 | Self-timed programming window active |
| arr_we | output | 4 | Per-offset array write enables in the commit cycle |
| arr_page | output | 5 | Page being written |
| arr_wdata | output | 32 | Four slot bytes, offset b at bits [8b+7:8b] |
| rd_addr | input | 7 | Array read address |
| rd_data | output | 8 | Registered array read data |

## Verification
The bench builds the block with `WRITE_CYCLES` set to 12. This makes the whole programming window short enough to count exactly. It is also long enough that open, byte, stop and abort requests, plus a read, can all be driven inside a single window. Address and width parameters stay at their defaults, so wrap at offset 3, mid-page starts and partial pages are reached on the real 128-byte array.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;

    localparam int DEF_ADDR_W       = 7;
    localparam int DEF_DATA_W       = 8;
    localparam int DEF_OFS_W        = 2;
    localparam int DEF_WRITE_CYCLES = 50000;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_FILL,
        SEQ_PROG
    } seq_state_e;

    // Per-cycle control decided by the sequencer
    typedef struct packed {
        logic open;    // load page/offset, clear slots
        logic take;    // store byte in current slot, step offset
        logic drop;    // clear all slot valid flags
        logic commit;  // write valid slots to the array
    } seq_ctl_t;

    function automatic int cnt_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/pgwr_seq.sv
module pgwr_seq
    import pgwr_pkg::*;
#(
    parameter int WRITE_CYCLES = DEF_WRITE_CYCLES
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     open_req,
    input  logic     byte_req,
    input  logic     stop_req,
    input  logic     abort_req,
    input  logic     any_vld,
    output seq_ctl_t ctl,
    output logic     busy
);

    localparam int CNT_W = cnt_width(WRITE_CYCLES);

    seq_state_e       st_q;
    logic [CNT_W-1:0] cnt_q;
    logic             last_cyc;

    assign last_cyc = (cnt_q == '0);
    assign busy     = (st_q == SEQ_PROG);

    always_comb begin
        ctl = '0;
        case (st_q)
            SEQ_IDLE: begin
                ctl.open = open_req && !stop_req && !abort_req;
            end
            SEQ_FILL: begin
                if (abort_req) begin
                    ctl.drop = 1'b1;
                end else if (stop_req) begin
                    ctl.drop = !any_vld;
                end else if (open_req) begin
                    ctl.open = 1'b1;
                end else begin
                    ctl.take = byte_req;
                end
            end
            SEQ_PROG: begin
                ctl.commit = last_cyc;
                ctl.drop   = last_cyc;
            end
            default: ctl = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= SEQ_IDLE;
            cnt_q <= '0;
        end else begin
            case (st_q)
                SEQ_IDLE: begin
                    if (ctl.open) st_q <= SEQ_FILL;
                end
                SEQ_FILL: begin
                    if (abort_req) begin
                        st_q <= SEQ_IDLE;
                    end else if (stop_req) begin
                        st_q  <= any_vld ? SEQ_PROG : SEQ_IDLE;
                        cnt_q <= CNT_W'(WRITE_CYCLES - 1);
                    end
                end
                SEQ_PROG: begin
                    if (last_cyc) st_q <= SEQ_IDLE;
                    else          cnt_q <= cnt_q - 1'b1;
                end
                default: st_q <= SEQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pgwr_page_latch.sv
module pgwr_page_latch #(
    parameter int DATA_W = 8,
    parameter int OFS_W  = 2,
    parameter int PAGE_W = 5,
    localparam int SLOTS = 1 << OFS_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    open_i,
    input  logic                    take_i,
    input  logic                    drop_i,
    input  logic [PAGE_W+OFS_W-1:0] addr_i,
    input  logic [DATA_W-1:0]       byte_i,
    output logic [PAGE_W-1:0]       page_o,
    output logic [SLOTS-1:0]        vld_o,
    output logic [SLOTS*DATA_W-1:0] data_o
);

    logic [PAGE_W-1:0] page_q;
    logic [OFS_W-1:0]  ofs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q <= '0;
            ofs_q  <= '0;
        end else if (open_i) begin
            page_q <= addr_i[PAGE_W+OFS_W-1:OFS_W];
            ofs_q  <= addr_i[OFS_W-1:0];
        end else if (take_i) begin
            ofs_q  <= ofs_q + 1'b1;
        end
    end

    assign page_o = page_q;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic              vld_q;
        logic [DATA_W-1:0] dat_q;
        logic              hit;

        assign hit = take_i && (ofs_q == OFS_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                vld_q <= 1'b0;
                dat_q <= '0;
            end else if (open_i || drop_i) begin
                vld_q <= 1'b0;
            end else if (hit) begin
                vld_q <= 1'b1;
                dat_q <= byte_i;
            end
        end

        assign vld_o[g]                   = vld_q;
        assign data_o[g*DATA_W +: DATA_W] = dat_q;
    end

endmodule

// File: rtl/pgwr_store.sv
module pgwr_store #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8,
    parameter int OFS_W  = 2,
    localparam int SLOTS  = 1 << OFS_W,
    localparam int PAGE_W = ADDR_W - OFS_W,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [SLOTS-1:0]        we_i,
    input  logic [PAGE_W-1:0]       page_i,
    input  logic [SLOTS*DATA_W-1:0] data_i,
    input  logic                    hold_i,
    input  logic [ADDR_W-1:0]       rd_addr_i,
    output logic [DATA_W-1:0]       rd_data_o
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            for (int b = 0; b < SLOTS; b++) begin
                if (we_i[b]) mem[{page_i, OFS_W'(b)}] <= data_i[b*DATA_W +: DATA_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          rd_data_o <= '0;
        else if (!hold_i) rd_data_o <= mem[rd_addr_i];
    end

endmodule

// File: rtl/pgwr_commit.sv
module pgwr_commit
    import pgwr_pkg::*;
#(
    parameter int ADDR_W       = DEF_ADDR_W,
    parameter int DATA_W       = DEF_DATA_W,
    parameter int OFS_W        = DEF_OFS_W,
    parameter int WRITE_CYCLES = DEF_WRITE_CYCLES,
    localparam int SLOTS  = 1 << OFS_W,
    localparam int PAGE_W = ADDR_W - OFS_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_open,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic                    wr_byte_vld,
    input  logic [DATA_W-1:0]       wr_byte,
    input  logic                    wr_stop,
    input  logic                    wr_abort,
    output logic                    busy,
    output logic [SLOTS-1:0]        arr_we,
    output logic [PAGE_W-1:0]       arr_page,
    output logic [SLOTS*DATA_W-1:0] arr_wdata,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [DATA_W-1:0]       rd_data
);

    seq_ctl_t                ctl;
    logic [SLOTS-1:0]        slot_vld;
    logic [PAGE_W-1:0]       slot_page;
    logic [SLOTS*DATA_W-1:0] slot_data;

    pgwr_seq #(
        .WRITE_CYCLES(WRITE_CYCLES)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .open_req (wr_open),
        .byte_req (wr_byte_vld),
        .stop_req (wr_stop),
        .abort_req(wr_abort),
        .any_vld  (|slot_vld),
        .ctl      (ctl),
        .busy     (busy)
    );

    pgwr_page_latch #(
        .DATA_W(DATA_W),
        .OFS_W (OFS_W),
        .PAGE_W(PAGE_W)
    ) u_latch (
        .clk   (clk),
        .rst   (rst),
        .open_i(ctl.open),
        .take_i(ctl.take),
        .drop_i(ctl.drop),
        .addr_i(wr_addr),
        .byte_i(wr_byte),
        .page_o(slot_page),
        .vld_o (slot_vld),
        .data_o(slot_data)
    );

    assign arr_we    = ctl.commit ? slot_vld : '0;
    assign arr_page  = slot_page;
    assign arr_wdata = slot_data;

    pgwr_store #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .OFS_W (OFS_W)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .we_i     (arr_we),
        .page_i   (slot_page),
        .data_i   (slot_data),
        .hold_i   (busy),
        .rd_addr_i(rd_addr),
        .rd_data_o(rd_data)
    );

endmodule

// File: rtl/pgwr_commit_chk.sv
module pgwr_commit_chk #(
    parameter int WRITE_CYCLES = 4,
    parameter int SLOTS        = 4,
    parameter int DATA_W       = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              wr_stop,
    input logic              wr_abort,
    input logic [SLOTS-1:0]  arr_we,
    input logic [DATA_W-1:0] rd_data
);

    int unsigned run_len;

    always_ff @(posedge clk) begin
        if (rst)       run_len <= 0;
        else if (busy) run_len <= run_len + 1;
        else           run_len <= 0;
    end

    AST_BUSY_AFTER_STOP: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(wr_stop));                           // R6
    AST_BUSY_WINDOW: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (run_len == WRITE_CYCLES));                 // R6
    AST_ABORT_NO_BUSY: assert property (@(posedge clk) disable iff (rst)
        (!busy && wr_abort) |=> !busy);                             // R8
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(rd_data));                                 // R10
    AST_WE_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (|arr_we) |-> busy);                                        // R11
    AST_WE_LAST_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (|arr_we) |=> !busy);                                       // R11

endmodule

bind pgwr_commit pgwr_commit_chk #(
    .WRITE_CYCLES(WRITE_CYCLES),
    .SLOTS       (SLOTS),
    .DATA_W      (DATA_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .busy    (busy),
    .wr_stop (wr_stop),
    .wr_abort(wr_abort),
    .arr_we  (arr_we),
    .rd_data (rd_data)
);

// File: tb/tb_pgwr_commit.sv
module tb_pgwr_commit;

    localparam int W = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_open = 1'b0;
    logic [6:0]  wr_addr = '0;
    logic        wr_byte_vld = 1'b0;
    logic [7:0]  wr_byte = '0;
    logic        wr_stop = 1'b0;
    logic        wr_abort = 1'b0;
    logic        busy;
    logic [3:0]  arr_we;
    logic [4:0]  arr_page;
    logic [31:0] arr_wdata;
    logic [6:0]  rd_addr = '0;
    logic [7:0]  rd_data;

    pgwr_commit #(.WRITE_CYCLES(W)) dut (
        .clk(clk), .rst(rst), .wr_open(wr_open), .wr_addr(wr_addr),
        .wr_byte_vld(wr_byte_vld), .wr_byte(wr_byte), .wr_stop(wr_stop),
        .wr_abort(wr_abort), .busy(busy), .arr_we(arr_we), .arr_page(arr_page),
        .arr_wdata(arr_wdata), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always #10 clk = ~clk;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // bench model built from the requirements
    logic [7:0] exp_mem [128];
    bit         m_active, m_busy;
    logic [4:0] m_page;
    logic [1:0] m_ofs;
    bit         m_val [4];
    logic [7:0] m_dat [4];

    typedef struct {
        logic [6:0] a;
        logic [7:0] e;
        string      tag;
    } rd_item_t;
    rd_item_t sb_q[$];

    int run_cnt = 0;
    int last_len = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(posedge clk);
            if (sb_q.size() != 0) begin
                rd_item_t it;
                @(negedge clk);
                it = sb_q.pop_front();
                check({it.tag, " read"}, {24'd0, rd_data}, {24'd0, it.e});
            end
        end
    end

    // busy window length monitor
    initial begin
        forever begin
            @(negedge clk);
            if (busy) run_cnt++;
            else if (run_cnt != 0) begin
                last_len = run_cnt;
                run_cnt  = 0;
            end
        end
    end

    task automatic rd(input logic [6:0] a, input string tag);
        rd_item_t it;
        @(negedge clk);
        it.e   = m_busy ? exp_mem[rd_addr] : exp_mem[a];
        it.a   = a;
        it.tag = tag;
        rd_addr = a;
        sb_q.push_back(it);
    endtask

    task automatic do_open(input logic [6:0] a);
        @(negedge clk);
        wr_open = 1'b1; wr_addr = a;
        @(negedge clk);
        wr_open = 1'b0;
        if (!m_busy) begin
            m_active = 1; m_page = a[6:2]; m_ofs = a[1:0];
            for (int b = 0; b < 4; b++) m_val[b] = 0;
        end
    endtask

    task automatic do_byte(input logic [7:0] d);
        @(negedge clk);
        wr_byte_vld = 1'b1; wr_byte = d;
        @(negedge clk);
        wr_byte_vld = 1'b0;
        if (!m_busy && m_active) begin
            m_dat[m_ofs] = d; m_val[m_ofs] = 1; m_ofs = m_ofs + 2'd1;
        end
    endtask

    task automatic do_abort();
        @(negedge clk);
        wr_abort = 1'b1;
        @(negedge clk);
        wr_abort = 1'b0;
        if (!m_busy && m_active) begin
            m_active = 0;
            for (int b = 0; b < 4; b++) m_val[b] = 0;
        end
    endtask

    task automatic do_stop(input string tag);
        bit any;
        bit was_busy;
        was_busy = m_busy;
        any = 0;
        for (int b = 0; b < 4; b++) any |= m_val[b];
        @(negedge clk);
        wr_stop = 1'b1;
        @(negedge clk);
        wr_stop = 1'b0;
        if (!was_busy) begin
            if (m_active && any) m_busy = 1;
            else for (int b = 0; b < 4; b++) m_val[b] = 0;
            m_active = 0;
            check({tag, " busy after stop"}, {31'd0, busy}, {31'd0, m_busy});
        end
    endtask

    task automatic wait_idle(input string tag);
        int guard = 0;
        while (busy && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
        check({tag, " busy window length"}, last_len, W);
        for (int b = 0; b < 4; b++)
            if (m_val[b]) exp_mem[{m_page, 2'(b)}] = m_dat[b];
        for (int b = 0; b < 4; b++) m_val[b] = 0;
        m_busy = 0;
    endtask

    initial begin
        for (int i = 0; i < 128; i++) exp_mem[i] = '0;
        m_active = 0; m_busy = 0; m_page = '0; m_ofs = '0;
        for (int b = 0; b < 4; b++) begin m_val[b] = 0; m_dat[b] = '0; end

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 busy", {31'd0, busy}, 32'd0);
        check("R1 arr_we", {28'd0, arr_we}, 32'd0);
        check("R1 rd_data", {24'd0, rd_data}, 32'd0);
        rd(7'h00, "R1"); rd(7'h05, "R1"); rd(7'h7F, "R1");

        // R2 single byte
        do_open(7'h15); do_byte(8'hA5); do_stop("R6");
        wait_idle("R6");
        rd(7'h15, "R2"); rd(7'h14, "R2"); rd(7'h16, "R2");

        // R3 mid-page start wraps within page
        do_open(7'h22);
        do_byte(8'h11); do_byte(8'h22); do_byte(8'h33); do_byte(8'h44);
        do_stop("R3"); wait_idle("R3");
        rd(7'h22, "R3"); rd(7'h23, "R3"); rd(7'h20, "R3"); rd(7'h21, "R3");
        rd(7'h24, "R3"); rd(7'h1F, "R3");

        // R5 no write before stop
        do_open(7'h40); do_byte(8'h77);
        rd(7'h40, "R5");
        do_stop("R5"); wait_idle("R5");
        rd(7'h40, "R5");

        // R4 more than four bytes overwrite
        do_open(7'h50);
        for (int k = 1; k <= 6; k++) do_byte(8'(8'hB0 + k));
        do_stop("R4"); wait_idle("R4");
        rd(7'h50, "R4"); rd(7'h51, "R4"); rd(7'h52, "R4"); rd(7'h53, "R4");

        // R7 partial page keeps unreceived locations
        do_open(7'h60);
        do_byte(8'hC0); do_byte(8'hC1); do_byte(8'hC2); do_byte(8'hC3);
        do_stop("R7"); wait_idle("R7");
        do_open(7'h61); do_byte(8'hD1); do_byte(8'hD2);
        do_stop("R7"); wait_idle("R7");
        rd(7'h60, "R7"); rd(7'h61, "R7"); rd(7'h62, "R7"); rd(7'h63, "R7");

        // R8 empty stop and abort
        do_open(7'h70); do_stop("R8");
        do_open(7'h70); do_byte(8'hEE); do_abort();
        @(negedge clk);
        check("R8 busy after abort", {31'd0, busy}, 32'd0);
        do_stop("R8");
        rd(7'h70, "R8");

        // R9 / R10 requests and reads during the window
        do_open(7'h08); do_byte(8'h5A); do_stop("R9");
        rd(7'h15, "R10");
        do_open(7'h0C); do_byte(8'h99); do_stop("R9"); do_abort();
        wait_idle("R9");
        rd(7'h0C, "R9"); rd(7'h08, "R9"); rd(7'h15, "R10");
        do_stop("R9");
        @(negedge clk);
        check("R9 no busy from stale stop", {31'd0, busy}, 32'd0);

        // full sweep
        for (int i = 0; i < 128; i++) rd(7'(i), "R2");
        repeat (3) @(negedge clk);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL R6 watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule